// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This block holds a free-running cycle counter and a compare value, and raises a timer interrupt when the two meet. The counter advances once for every two pipeline clocks. After each advance, the low 32 bits of the counter are matched against the low 32 bits of the compare value. A match latches a timer-pending bit, which stays set until software writes the compare value again.

The block also folds the processor's interrupt controls into a single request line. The timer-pending bit and seven external pending inputs form an 8-bit pending field. That field is masked by an 8-bit enable mask. The result is gated by the global enable and by the exception-level and error-level flags. Software can load the counter at any time. Such a load wins over an increment in the same cycle and restarts the half-rate phase.

Top module: `timer_irq_unit`

## Requirements
- R1: While `rstN` is low, and after it is released until the first edge, `count`, `compare` and `timerPending` are zero. `irqReq` is zero whenever `timerPending` is zero and no enabled external bit is set.
- R2: After reset is released, `count` increments by one on every second rising clock edge. The first increment occurs on the second edge after release.
- R3: When an increment makes the low 32 bits of the new `count` equal to the low 32 bits of `compare`, `timerPending` is set on that edge. The upper 32 bits of both values take no part in the match, and a match reached by wrapping to zero counts.
- R4: A compare write (`compareWrEn` high at an edge) loads all 64 bits of `wrData` into `compare` and clears `timerPending`. The clear wins over a match set on the same edge.
- R5: Once set, `timerPending` stays set until a compare write. Meanwhile `count` keeps running and wraps from all ones to zero.
- R6: A count write (`countWrEn` high at an edge) loads `wrData` into `count` exactly, with no increment on that edge. The next increment follows on the second edge after the write. A count write never sets `timerPending`, even when the loaded value equals `compare`.
- R7: `irqReq` is combinational and equals `statusIe & ~statusExl & ~statusErl & |(statusIm & ip)`. Here `ip[7]` is `timerPending` and `ip[k]` is `extPending[k]` for k = 0..6.
- R8: Each bit of `statusIm` enables only its own bit of `ip`. A pending bit whose mask bit is zero never raises `irqReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rstN | input | 1 | Asynchronous active-low reset |
| countWrEn | input | 1 | Load `wrData` into the counter |
| compareWrEn | input | 1 | Load `wrData` into compare and clear the timer pending bit |
| wrData | input | 64 | Write data for counter or compare |
| statusIe | input | 1 | Global interrupt enable |
| statusExl | input | 1 | Exception-level flag; blocks the request |
| statusErl | input | 1 | Error-level flag; blocks the request |
| statusIm | input | 8 | Per-bit interrupt mask |
| extPending | input | 7 | External pending bits, mapped to ip[6:0] |
| count | output | 64 | Current counter value |
| compare | output | 64 | Current compare value |
| timerPending | output | 1 | Timer pending bit, ip[7] |
| irqReq | output | 1 | Combined interrupt request |

## Verification
The request gating is tried with a table of enable, flag, mask and external-bit patterns:
- Single mismatched mask bits separate per-bit masking from a plain OR of all pending bits.
- Each of IE, EXL and ERL is toggled alone to show that each one gates the request on its own.

Timer matching is tried in four ways:
- A compare value whose upper half differs from the counter's shows that only the low halves are matched.
- A count load equal to compare shows that loads do not match.
- A compare write landing on an increment edge shows that the clear wins over the set.
- A load of all ones shows the wrap to zero and a match at zero.

A count load placed on an increment edge tells a correct load priority and phase restart apart from a load that is then incremented.

// File: rtl/timer_irq_pkg.sv
package timer_irq_pkg;
  // Strobes issued by the control to the datapath each cycle.
  typedef struct packed {
    logic incEn;
    logic countLoad;
    logic compareLoad;
  } tmrStrobe_t;
endpackage

// File: rtl/timer_irq_ctrl.sv
module timer_irq_ctrl
  import timer_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       countWrEn,
  input  logic       compareWrEn,
  output tmrStrobe_t strb
);
  // Half-rate phase: increment happens on edges where phase is 1.
  logic phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          phase <= 1'b0;
    else if (countWrEn) phase <= 1'b0;   // load restarts the phase
    else                phase <= ~phase;
  end

  always_comb begin
    strb.countLoad   = countWrEn;
    strb.compareLoad = compareWrEn;
    strb.incEn       = phase & ~countWrEn;
  end

  // R2: increments never occur on two consecutive edges.
  p_half_rate_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.incEn |=> !strb.incEn);

  // R6: the edge after a count load never increments.
  p_load_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.countLoad |=> !strb.incEn);
endmodule

// File: rtl/timer_irq_dp.sv
module timer_irq_dp
  import timer_irq_pkg::*;
#(
  parameter int COUNT_W = 64,
  parameter int MATCH_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  tmrStrobe_t         strb,
  input  logic [COUNT_W-1:0] wrData,
  output logic [COUNT_W-1:0] count,
  output logic [COUNT_W-1:0] compare,
  output logic               timerPending
);
  localparam logic [COUNT_W-1:0] STEP = COUNT_W'(1);

  logic [COUNT_W-1:0] countInc;
  logic               lowMatch;

  assign countInc = count + STEP;
  assign lowMatch = (countInc[MATCH_W-1:0] == compare[MATCH_W-1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               count <= '0;
    else if (strb.countLoad) count <= wrData;
    else if (strb.incEn)     count <= countInc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 compare <= '0;
    else if (strb.compareLoad) compare <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       timerPending <= 1'b0;
    else if (strb.compareLoad)       timerPending <= 1'b0;
    else if (strb.incEn && lowMatch) timerPending <= 1'b1;
  end

  // R2: without a strobe the counter holds.
  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.countLoad && !strb.incEn) |=> $stable(count));

  // R2: an increment moves the counter by exactly one.
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.incEn |=> (count == $past(count) + STEP));

  // R6: a load takes the written value.
  p_count_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.countLoad |=> (count == $past(wrData)));

  // R4: a compare write always leaves the pending bit clear.
  p_cmp_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.compareLoad |=> !timerPending);

  // R5: pending is sticky until a compare write.
  p_pend_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (timerPending && !strb.compareLoad) |=> timerPending);

  // R3: pending rises only on an increment edge.
  p_pend_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timerPending) |-> $past(strb.incEn));
endmodule

// File: rtl/timer_irq_req.sv
module timer_irq_req #(
  parameter int IP_W = 8
) (
  input  logic            statusIe,
  input  logic            statusExl,
  input  logic            statusErl,
  input  logic [IP_W-1:0] statusIm,
  input  logic [IP_W-2:0] extPending,
  input  logic            timerPending,
  output logic            irqReq
);
  logic [IP_W-1:0] ipField;
  logic [IP_W-1:0] enabled;

  // Timer bit at the top of the field; external bits below it.
  assign ipField = {timerPending, extPending};

  for (genvar k = 0; k < IP_W; k++) begin : g_mask
    assign enabled[k] = ipField[k] & statusIm[k];
  end

  assign irqReq = statusIe & ~(statusExl | statusErl) & (|enabled);
endmodule

// File: rtl/timer_irq_unit.sv
module timer_irq_unit
  import timer_irq_pkg::*;
#(
  parameter int COUNT_W = 64,
  parameter int MATCH_W = 32,
  parameter int IP_W    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               countWrEn,
  input  logic               compareWrEn,
  input  logic [COUNT_W-1:0] wrData,
  input  logic               statusIe,
  input  logic               statusExl,
  input  logic               statusErl,
  input  logic [IP_W-1:0]    statusIm,
  input  logic [IP_W-2:0]    extPending,
  output logic [COUNT_W-1:0] count,
  output logic [COUNT_W-1:0] compare,
  output logic               timerPending,
  output logic               irqReq
);
  tmrStrobe_t strb;

  timer_irq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .countWrEn   (countWrEn),
    .compareWrEn (compareWrEn),
    .strb        (strb)
  );

  timer_irq_dp #(.COUNT_W(COUNT_W), .MATCH_W(MATCH_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .wrData       (wrData),
    .count        (count),
    .compare      (compare),
    .timerPending (timerPending)
  );

  timer_irq_req #(.IP_W(IP_W)) u_req (
    .statusIe     (statusIe),
    .statusExl    (statusExl),
    .statusErl    (statusErl),
    .statusIm     (statusIm),
    .extPending   (extPending),
    .timerPending (timerPending),
    .irqReq       (irqReq)
  );

  // R7: any blocking flag or a cleared enable keeps the request low.
  p_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!statusIe || statusExl || statusErl) |-> !irqReq);

  // R8: with the timer bit masked off and no external bit set, no request.
  p_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!statusIm[IP_W-1] && extPending == '0) |-> !irqReq);
endmodule

// File: tb/timer_irq_unit_bench.sv
module timer_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        countWrEn = 1'b0;
  logic        compareWrEn = 1'b0;
  logic [63:0] wrData = '0;
  logic        statusIe = 1'b0;
  logic        statusExl = 1'b0;
  logic        statusErl = 1'b0;
  logic [7:0]  statusIm = '0;
  logic [6:0]  extPending = '0;
  logic [63:0] count;
  logic [63:0] compare;
  logic        timerPending;
  logic        irqReq;

  int testCount = 0;
  int failCount = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  timer_irq_unit u_timer_irq_unit (
    .clk(clk), .rstN(rstN), .countWrEn(countWrEn), .compareWrEn(compareWrEn),
    .wrData(wrData), .statusIe(statusIe), .statusExl(statusExl),
    .statusErl(statusErl), .statusIm(statusIm), .extPending(extPending),
    .count(count), .compare(compare), .timerPending(timerPending),
    .irqReq(irqReq)
  );

  // Gating vectors: {ie, exl, erl, im[7:0], ext[6:0], expected irq}
  localparam logic [18:0] GATE_VEC [8] = '{
    {1'b1, 1'b0, 1'b0, 8'hFF, 7'h01, 1'b1},  // R7 all open
    {1'b0, 1'b0, 1'b0, 8'hFF, 7'h01, 1'b0},  // R7 IE low
    {1'b1, 1'b1, 1'b0, 8'hFF, 7'h01, 1'b0},  // R7 EXL
    {1'b1, 1'b0, 1'b1, 8'hFF, 7'h01, 1'b0},  // R7 ERL
    {1'b1, 1'b0, 1'b0, 8'h02, 7'h01, 1'b0},  // R8 mask mismatch
    {1'b1, 1'b0, 1'b0, 8'h40, 7'h40, 1'b1},  // R8 single match
    {1'b1, 1'b0, 1'b0, 8'h80, 7'h7F, 1'b0},  // R8 timer bit only, not pending
    {1'b1, 1'b0, 1'b0, 8'h7F, 7'h00, 1'b0}   // R8 nothing pending
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic writeCount(input logic [63:0] v);
    wrData = v; countWrEn = 1'b1;
    step();
    countWrEn = 1'b0;
  endtask

  task automatic writeCompare(input logic [63:0] v);
    wrData = v; compareWrEn = 1'b1;
    step();
    compareWrEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: state held in reset
    check("R1 count in reset", count, 64'h0);
    check("R1 pending in reset", {63'h0, timerPending}, 64'h0);
    #3 rstN = 1'b1;
    check("R1 count", count, 64'h0);
    check("R1 compare", compare, 64'h0);
    check("R1 pending", {63'h0, timerPending}, 64'h0);
    check("R1 irq", {63'h0, irqReq}, 64'h0);

    // Table walk of request gating (R7, R8)
    for (int i = 0; i < 8; i++) begin
      {statusIe, statusExl, statusErl, statusIm, extPending} = GATE_VEC[i][18:1];
      #1;
      check($sformatf("R7/R8 gate vector %0d", i), {63'h0, irqReq}, {63'h0, GATE_VEC[i][0]});
    end
    statusIe = 0; statusExl = 0; statusErl = 0; statusIm = '0; extPending = '0;

    // R2: half-rate counting
    step();
    check("R2 no inc on first edge", count, 64'h0);
    step();
    check("R2 inc on second edge", count, 64'h1);
    repeat (8) step();
    check("R2 ten edges give five", count, 64'h5);

    // R3: match on low half only
    writeCompare(64'hABCD_0000_0000_0010);
    check("R4 compare loaded", compare, 64'hABCD_0000_0000_0010);
    writeCount(64'h0000_0007_0000_000C);
    check("R6 count loaded", count, 64'h0000_0007_0000_000C);
    repeat (7) step();
    check("R3 no pending before match", {63'h0, timerPending}, 64'h0);
    check("R3 count before match", count, 64'h0000_0007_0000_000F);
    step();
    check("R3 count at match", count, 64'h0000_0007_0000_0010);
    check("R3 pending on low-half match", {63'h0, timerPending}, 64'h1);

    // R7: timer bit raises request
    statusIe = 1'b1; statusIm = 8'h80;
    #1;
    check("R7 timer irq", {63'h0, irqReq}, 64'h1);
    statusExl = 1'b1;
    #1;
    check("R7 EXL blocks timer irq", {63'h0, irqReq}, 64'h0);
    statusExl = 1'b0;

    // R5: sticky while counting
    repeat (6) step();
    check("R5 pending sticky", {63'h0, timerPending}, 64'h1);
    check("R5 count runs", count, 64'h0000_0007_0000_0013);

    // R4: compare write clears
    writeCompare(64'h20);
    check("R4 pending cleared", {63'h0, timerPending}, 64'h0);
    check("R4 irq dropped", {63'h0, irqReq}, 64'h0);
    check("R4 compare value", compare, 64'h20);

    // R4: clear wins over same-edge match
    writeCount(64'h1F);
    step();
    wrData = 64'h20; compareWrEn = 1'b1;
    step();
    compareWrEn = 1'b0;
    check("R4 count reached match", count, 64'h20);
    check("R4 clear wins over set", {63'h0, timerPending}, 64'h0);

    // R6: load equal to compare does not set pending
    writeCount(64'h20);
    check("R6 load equal no pending", {63'h0, timerPending}, 64'h0);
    step();
    check("R6 still no pending", {63'h0, timerPending}, 64'h0);

    // R6: load on an increment edge wins and restarts phase
    writeCount(64'h100);
    step();
    writeCount(64'h500);
    check("R6 load beats increment", count, 64'h500);
    step();
    check("R6 phase restarted", count, 64'h500);
    step();
    check("R6 increment after restart", count, 64'h501);

    // R5/R3: wrap to zero and match at zero
    writeCompare(64'h0);
    writeCount(64'hFFFF_FFFF_FFFF_FFFF);
    step();
    check("R5 before wrap", count, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R3 no pending before wrap", {63'h0, timerPending}, 64'h0);
    step();
    check("R5 wrap to zero", count, 64'h0);
    check("R3 match at wrap", {63'h0, timerPending}, 64'h1);

    finishRun();
  end
endmodule